// File: doc/BRIEF.md
# Level-and-Priority Interrupt Arbiter

This block takes ten internal interrupt request lines and four external request pins and picks the most urgent pending request. Each internal source has a byte-wide control register. The register sets the source's level from 1 to 7 and its priority from 0 to 3 within that level. It also chooses whether the acknowledge is answered with an autovector or with a vector that the device supplies. Each external pin has a fixed level and takes the top slot at that level. A small register holds one autovector bit per external pin.

The block sends the processor a registered 3-bit request level: the highest level among the enabled pending sources. When the processor acknowledges a level, the block answers on the next cycle. The answer gives the winning source's code and its autovector choice. If nothing is pending at that level, the answer is marked spurious. Software programs the block through a plain byte-wide write port with a combinational read-back.

Top module: `irq_rank_arbiter`

## Requirements
- R1: After reset every control register reads 0x00, the external autovector register reads 0x00, and ipl, ack_done, ack_src, ack_avec and ack_spur are all 0.
- R2: Control register i (0 to 9) is at address 0x4C+i. Its bit 7 is the autovector enable, bits 4:2 are the level and bits 1:0 are the priority. Bits 6:5 always read as zero, so writing 0xFF reads back 0x9F.
- R3: An internal source whose level field is 0 never requests service. It does not raise ipl and never wins an acknowledge.
- R4: ipl is the highest level among the pending enabled sources, or 0 if none is pending. It is registered and reflects inputs and registers one clock after they change.
- R5: Among internal sources pending at the acknowledged level, the higher priority code wins, in the order 11 > 10 > 01 > 00.
- R6: Internal sources pending with equal level and equal priority are resolved in favour of the lower register index.
- R7: External pin k (0 to 3) has the fixed level 2k+1 (levels 1, 3, 5, 7). When it is pending, it beats every internal source at that level. Its source code is 10+k.
- R8: An acknowledge is a one-cycle ack_valid pulse with a level on ack_level. On the next clock, ack_done is 1 for one cycle. ack_src gives the winner's code (internal index 0 to 9) and ack_avec gives the winner's autovector bit.
- R9: If no source is pending at the acknowledged level, or that level is 0, the answer has ack_spur = 1, ack_src = 0 and ack_avec = 0.
- R10: The external autovector register is at address 0x56. Bit k is pin k's autovector choice. Bits 7:4 read zero.
- R11: Any other address reads 0x00. A write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_req | input | 10 | Internal request lines, active high |
| ext_req | input | 4 | External request pins, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data at addr |
| ipl | output | 3 | Registered encoded request level to the processor |
| ack_valid | input | 1 | Acknowledge cycle request |
| ack_level | input | 3 | Level being acknowledged |
| ack_done | output | 1 | Acknowledge answer valid, one cycle after ack_valid |
| ack_src | output | 4 | Winning source code (0 to 9 internal, 10 to 13 external) |
| ack_avec | output | 1 | 1 for autovector, 0 for a device-supplied vector |
| ack_spur | output | 1 | No source pending at the acknowledged level |

## Verification
A corrupted control register appears at once on read-back. It appears on ipl one clock later, and in the answer to the next acknowledge at the affected level. A wrong ranking inside the selection logic cannot be seen on ipl when only the order within a level is wrong. It appears only in ack_src or ack_avec one cycle after an acknowledge. For that reason, every sweep acknowledges the level in question as well as checking ipl. The sweeps cover each source alone at every level, priority and autovector setting, every pair of sources in every priority combination, every external pin against an internal rival, and a long run of pseudo-random configurations.

// File: rtl/irq_rank_arbiter.sv
module irq_rank_arbiter #(
  parameter int N_INT = 10,
  parameter int N_EXT = 4,
  parameter logic [7:0] BASE = 8'h4C
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [N_INT-1:0]                   int_req,
  input  logic [N_EXT-1:0]                   ext_req,
  input  logic                               wr_en,
  input  logic [7:0]                         addr,
  input  logic [7:0]                         wdata,
  output logic [7:0]                         rdata,
  output logic [2:0]                         ipl,
  input  logic                               ack_valid,
  input  logic [2:0]                         ack_level,
  output logic                               ack_done,
  output logic [$clog2(N_INT+N_EXT)-1:0]     ack_src,
  output logic                               ack_avec,
  output logic                               ack_spur
);
  localparam int NS = N_INT + N_EXT;
  localparam int SW = $clog2(NS);
  localparam logic [7:0] XADDR = BASE + 8'(N_INT);
  localparam logic [7:0] KEEP = 8'h9F;

  logic [7:0]       cfg_q [N_INT];
  logic [N_EXT-1:0] xav_q;
  logic [2:0]       top_lvl;
  logic             hit;
  logic [1:0]       best_p;
  logic [SW-1:0]    win;
  logic             win_av;

  function automatic logic [2:0] ext_lvl(input int k);
    return 3'(2 * k + 1);
  endfunction

  for (genvar i = 0; i < N_INT; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cfg_q[i] <= '0;
      else if (wr_en && addr == BASE + 8'(i)) cfg_q[i] <= wdata & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) xav_q <= '0;
    else if (wr_en && addr == XADDR) xav_q <= wdata[N_EXT-1:0];

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_INT; i++)
      if (addr == BASE + 8'(i)) rdata = cfg_q[i];
    if (addr == XADDR) rdata = 8'(xav_q);
  end

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < N_INT; i++)
      if (int_req[i] && cfg_q[i][4:2] > top_lvl) top_lvl = cfg_q[i][4:2];
    for (int k = 0; k < N_EXT; k++)
      if (ext_req[k] && ext_lvl(k) > top_lvl) top_lvl = ext_lvl(k);
  end

  always_comb begin
    hit = 1'b0;
    best_p = '0;
    win = '0;
    win_av = 1'b0;
    for (int i = N_INT - 1; i >= 0; i--)
      if (int_req[i] && ack_level != 3'd0 && cfg_q[i][4:2] == ack_level &&
          (!hit || cfg_q[i][1:0] >= best_p)) begin
        hit = 1'b1;
        best_p = cfg_q[i][1:0];
        win = SW'(i);
        win_av = cfg_q[i][7];
      end
    for (int k = 0; k < N_EXT; k++)
      if (ext_req[k] && ext_lvl(k) == ack_level) begin
        hit = 1'b1;
        win = SW'(N_INT + k);
        win_av = xav_q[k];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ipl <= '0;
      ack_done <= 1'b0;
      ack_src <= '0;
      ack_avec <= 1'b0;
      ack_spur <= 1'b0;
    end else begin
      ipl <= top_lvl;
      ack_done <= ack_valid;
      ack_src <= (ack_valid && hit) ? win : '0;
      ack_avec <= ack_valid && hit && win_av;
      ack_spur <= ack_valid && !hit;
    end

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req == '0 && ext_req == '0) |=> ipl == 3'd0);

  assert_spur_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_spur |-> (ack_src == '0 && !ack_avec && ack_done));

  assert_src_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done && !ack_spur) |-> int'(ack_src) < NS);

  assert_no_level0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done && !ack_spur) |-> $past(ack_level) != 3'd0);

  assert_ext_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done && !ack_spur && int'(ack_src) >= N_INT) |->
      $past(ack_level) == 3'(2 * (int'(ack_src) - N_INT) + 1));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= BASE && addr < XADDR) |-> rdata[6:5] == 2'b00);
endmodule

// File: tb/sim_irq_rank_arbiter.sv
module sim_irq_rank_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] int_req = '0;
  logic [3:0] ext_req = '0;
  logic wr_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic [2:0] ipl;
  logic ack_valid = 1'b0;
  logic [2:0] ack_level = '0;
  logic ack_done, ack_avec, ack_spur;
  logic [3:0] ack_src;

  int checks = 0, errors = 0;
  logic [7:0] bcfg [10];
  logic [3:0] bxav;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  irq_rank_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .int_req(int_req), .ext_req(ext_req),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .ipl(ipl),
    .ack_valid(ack_valid), .ack_level(ack_level), .ack_done(ack_done),
    .ack_src(ack_src), .ack_avec(ack_avec), .ack_spur(ack_spur));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic int model_top();
    int t = 0;
    for (int i = 0; i < 10; i++)
      if (int_req[i] && int'(bcfg[i][4:2]) > t) t = int'(bcfg[i][4:2]);
    for (int k = 0; k < 4; k++)
      if (ext_req[k] && 2 * k + 1 > t) t = 2 * k + 1;
    return t;
  endfunction

  task automatic model_ack(input int l, output int src, output bit av, output bit sp);
    int bp = -1;
    src = 0; av = 1'b0; sp = 1'b1;
    if (l == 0) return;
    for (int k = 0; k < 4; k++)
      if (ext_req[k] && 2 * k + 1 == l) begin
        src = 10 + k; av = bxav[k]; sp = 1'b0; return;
      end
    for (int i = 0; i < 10; i++)
      if (int_req[i] && int'(bcfg[i][4:2]) == l && int'(bcfg[i][1:0]) > bp) begin
        bp = int'(bcfg[i][1:0]); src = i; av = bcfg[i][7]; sp = 1'b0;
      end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    if (a >= 8'h4C && a <= 8'h55) bcfg[a - 8'h4C] = d & 8'h9F;
    if (a == 8'h56) bxav = d[3:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    addr = a;
    #1;
    chk(rdata == exp, req, int'(rdata), int'(exp));
  endtask

  task automatic verify(input int l, input string req);
    int es; bit ea, esp;
    @(negedge clk);
    chk(int'(ipl) == model_top(), {req, " R4 ipl"}, int'(ipl), model_top());
    model_ack(l, es, ea, esp);
    ack_valid = 1'b1; ack_level = 3'(l);
    @(negedge clk);
    ack_valid = 1'b0;
    chk(ack_done && int'(ack_src) == es && ack_avec == ea && ack_spur == esp,
        {req, " R8 ack"}, {ack_done, ack_spur, ack_avec, ack_src},
        {1'b1, esp, ea, 4'(es)});
  endtask

  initial begin
    for (int i = 0; i < 10; i++) bcfg[i] = '0;
    bxav = '0;
    repeat (3) @(negedge clk);
    chk(ipl == 0 && !ack_done && ack_src == 0 && !ack_avec && !ack_spur, "R1 outputs",
        {ipl, ack_done, ack_avec, ack_spur, ack_src}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 11; i++) rd(8'(8'h4C + i), 8'h00, "R1 regs");

    wr(8'h4E, 8'hFF); rd(8'h4E, 8'h9F, "R2 reserved bits");
    wr(8'h56, 8'hFF); rd(8'h56, 8'h0F, "R10 ext reg");
    wr(8'h4B, 8'hFF); rd(8'h4B, 8'h00, "R11 unmapped low");
    wr(8'h57, 8'hFF); rd(8'h57, 8'h00, "R11 unmapped high");
    rd(8'h4E, 8'h9F, "R11 no side write");
    rd(8'h4C, 8'h00, "R11 no side write");
    wr(8'h4E, 8'h00); wr(8'h56, 8'h00);

    for (int l = 0; l < 8; l++) verify(l, "R9 idle spurious");

    for (int i = 0; i < 10; i++)
      for (int c = 0; c < 64; c++) begin
        logic [7:0] v = {c[5], 2'b00, c[4:2], c[1:0]};
        wr(8'(8'h4C + i), v);
        rd(8'(8'h4C + i), v, "R2 layout");
        int_req = 10'(1 << i);
        verify(int'(v[4:2]), (v[4:2] == 0) ? "R3 disabled" : "R8 single");
        int_req = '0;
        wr(8'(8'h4C + i), 8'h00);
      end

    for (int i = 0; i < 10; i++)
      for (int j = i + 1; j < 10; j++)
        for (int p = 0; p < 16; p++) begin
          wr(8'(8'h4C + i), {1'b0, 2'b00, 3'd3, 2'(p)});
          wr(8'(8'h4C + j), {1'b1, 2'b00, 3'd3, 2'(p >> 2)});
          int_req = 10'((1 << i) | (1 << j));
          verify(3, (p[1:0] == p[3:2]) ? "R6 tie" : "R5 priority");
          int_req = '0;
          wr(8'(8'h4C + i), 8'h00); wr(8'(8'h4C + j), 8'h00);
        end

    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 2; a++) begin
        wr(8'h56, 8'(a << k));
        wr(8'h4D, {1'b1, 2'b00, 3'(2 * k + 1), 2'b11});
        int_req = 10'b10;
        ext_req = 4'(1 << k);
        verify(2 * k + 1, "R7 ext wins R10 avec");
        ext_req = '0;
        verify(2 * k + 1, "R7 internal after ext drops");
        int_req = '0;
      end
    wr(8'h4D, 8'h00); wr(8'h56, 8'h00);

    for (int n = 0; n < 1500; n++) begin
      for (int i = 0; i < 10; i++) wr(8'(8'h4C + i), 8'(rnd()));
      wr(8'h56, 8'(rnd()));
      int_req = 10'(rnd());
      ext_req = 4'(rnd() & rnd());
      verify(int'(rnd() % 8), "R4 R5 R6 R7 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule